// File: doc/BRIEF.md
# Halt-Mode Power Sequencing Controller

This block steps a small microcontroller into its deepest stop state and brings it back out. A strobe from the core asks for a halt. The block checks the auto-wake setting and the watchdog configuration, and then does one of three things. It may ignore the request. It may turn the request into a watchdog reset. It may stop the oscillator, the peripheral clocks and the CPU clock. On entry it sends a one-cycle pulse that clears the interrupt mask, so that interrupts are enabled while the part is halted.

A reset request or a wake-capable interrupt ends the halt. If one of them is already present in the entry cycle, the halt ends at once. When the halt ends, the oscillator starts straight away. The CPU and peripheral clocks stay off until a stabilisation counter has seen 256 or 4096 ticks of an always-on timebase. When the delay is over, a single-cycle resume pulse tells the core whether to service the interrupt or fetch the reset vector. A reset has priority over an interrupt that arrives with it.

The main `clk` stands for the control logic's own clock. The always-on timebase reaches the block as the clock-enable `stab_tick`, so the counter advances only on those ticks.

Top module: `halt_seq_ctrl`

## Requirements
- R1: When `awake_en` is 1, a `halt_req` strobe is ignored. `state_o` stays RUN (code 0), all clock enables stay 1, and neither `imask_clr` nor `wdg_rst_req` pulses.
- R2: A halt request that is accepted makes `imask_clr` high for exactly one cycle. That cycle is the first cycle after the request edge.
- R3: If `wake_irq` or `rst_req` is high in the same cycle as an accepted halt request, the controller goes straight to STARTUP (code 2) and never shows HALTED (code 1).
- R4: In HALTED (code 1), `osc_en`, `periph_clk_en` and `cpu_clk_en` are all 0.
- R5: HALTED is left only when `wake_irq` or `rst_req` is high. Other inputs, including `halt_req`, `dly_long` and `stab_tick`, leave it in HALTED.
- R6: In STARTUP (code 2), `osc_en` is 1 and `cpu_clk_en` and `periph_clk_en` are 0. STARTUP ends after exactly 256 `stab_tick` pulses when `dly_long` was 0 at the wake cycle, and after 4096 pulses when it was 1.
- R7: After STARTUP, the controller spends one cycle in RESUME (code 3) with `resume_pulse` = 1 and all clocks enabled. `resume_is_reset` is 1 for a reset wake and 0 for an interrupt wake. The next cycle is RUN with `resume_pulse` = 0.
- R8: If `wdg_en` = 1 and `wdg_halt_opt` = 0, a halt request from RUN (with `awake_en` = 0) makes `wdg_rst_req` high for one cycle, and the state stays RUN.
- R9: If `wdg_en` = 0 or `wdg_halt_opt` = 1, a halt request from RUN (with `awake_en` = 0) enters HALTED.
- R10: If `rst_req` and `wake_irq` arrive together, the wake counts as a reset (`resume_is_reset` = 1).
- R11: After `rst`, the state is RUN, all clock enables are 1, and `imask_clr`, `wdg_rst_req` and `resume_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Halt instruction strobe |
| awake_en | input | 1 | Auto-wake enable; 1 routes halts elsewhere |
| wdg_en | input | 1 | Watchdog running |
| wdg_halt_opt | input | 1 | Watchdog-halt option; 0 turns a halt into a reset |
| wake_irq | input | 1 | Wake-capable interrupt request |
| rst_req | input | 1 | Reset request as a wake source |
| dly_long | input | 1 | Delay select: 0 short, 1 long |
| stab_tick | input | 1 | Always-on timebase tick for the stabilisation counter |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| imask_clr | output | 1 | One-cycle forced clear of the interrupt mask |
| wdg_rst_req | output | 1 | One-cycle watchdog reset request |
| resume_pulse | output | 1 | One-cycle resume strobe |
| resume_is_reset | output | 1 | With `resume_pulse`: 1 fetch reset vector, 0 service interrupt |
| state_o | output | 2 | State: 0 RUN, 1 HALTED, 2 STARTUP, 3 RESUME |

## Verification
The hardest path to reach is the halt that never rests in HALTED. The wake source has to be present in the very cycle the halt request is accepted. The bench drives `halt_req` together with `wake_irq`, `rst_req` or both on one edge. It then confirms that the next state is already STARTUP and that the mask-clear pulse is still produced. The stabilisation length is measured with an irregular tick pattern: the bench counts only the ticks it drives while STARTUP is shown and compares that count with 256 or 4096.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_HALTED  = 2'd1,
    ST_STARTUP = 2'd2,
    ST_RESUME  = 2'd3
  } hseq_state_t;

  typedef struct packed {
    logic osc;
    logic periph;
    logic cpu;
  } clk_enables_t;

  function automatic clk_enables_t enables_for(hseq_state_t s);
    clk_enables_t e;
    case (s)
      ST_HALTED:  e = '{osc: 1'b0, periph: 1'b0, cpu: 1'b0};
      ST_STARTUP: e = '{osc: 1'b1, periph: 1'b0, cpu: 1'b0};
      default:    e = '{osc: 1'b1, periph: 1'b1, cpu: 1'b1};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/halt_req_decode.sv
module halt_req_decode (
  input  logic halt_req,
  input  logic awake_en,
  input  logic wdg_en,
  input  logic wdg_halt_opt,
  input  logic in_run,
  output logic go_halt,
  output logic go_wdg
);
  logic valid_req;
  logic wdg_blocks;

  always_comb begin
    valid_req  = in_run && halt_req && !awake_en;
    wdg_blocks = wdg_en && !wdg_halt_opt;
    go_wdg     = valid_req && wdg_blocks;
    go_halt    = valid_req && !wdg_blocks;
  end
endmodule

// File: rtl/halt_stab_counter.sv
module halt_stab_counter #(
  parameter int SHORT_DELAY = 256,
  parameter int LONG_DELAY  = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic long_sel,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int MAX_DELAY = (LONG_DELAY > SHORT_DELAY) ? LONG_DELAY : SHORT_DELAY;
  localparam int CNT_W     = (MAX_DELAY > 2) ? $clog2(MAX_DELAY) : 1;
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_DELAY - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_DELAY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             long_q;
  logic [CNT_W-1:0] last;

  always_comb begin
    last = long_q ? LAST_LONG : LAST_SHORT;
    done = run && tick && (cnt_q == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      long_q <= long_sel;
    end else if (run && tick && !done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/halt_seq_fsm.sv
module halt_seq_fsm
  import halt_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        go_halt,
  input  logic        go_wdg,
  input  logic        wake_irq,
  input  logic        rst_req,
  input  logic        stab_done,
  output logic        in_run,
  output logic        stab_clr,
  output logic        stab_run,
  output logic        osc_en,
  output logic        periph_clk_en,
  output logic        cpu_clk_en,
  output logic        imask_clr,
  output logic        wdg_rst_req,
  output logic        resume_pulse,
  output logic        resume_is_reset,
  output logic [1:0]  state_o
);
  hseq_state_t  state_q, state_n;
  logic         src_rst_q, src_rst_n;
  logic         wake_any;
  clk_enables_t en_n;

  always_comb begin
    wake_any  = wake_irq || rst_req;
    state_n   = state_q;
    src_rst_n = src_rst_q;
    stab_clr  = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (go_halt) begin
          if (wake_any) begin
            state_n   = ST_STARTUP;
            src_rst_n = rst_req;
            stab_clr  = 1'b1;
          end else begin
            state_n = ST_HALTED;
          end
        end
      end
      ST_HALTED: begin
        if (wake_any) begin
          state_n   = ST_STARTUP;
          src_rst_n = rst_req;
          stab_clr  = 1'b1;
        end
      end
      ST_STARTUP: begin
        if (stab_done) state_n = ST_RESUME;
      end
      default: state_n = ST_RUN;
    endcase
    en_n     = enables_for(state_n);
    in_run   = (state_q == ST_RUN);
    stab_run = (state_q == ST_STARTUP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= ST_RUN;
      src_rst_q       <= 1'b0;
      osc_en          <= 1'b1;
      periph_clk_en   <= 1'b1;
      cpu_clk_en      <= 1'b1;
      imask_clr       <= 1'b0;
      wdg_rst_req     <= 1'b0;
      resume_pulse    <= 1'b0;
      resume_is_reset <= 1'b0;
    end else begin
      state_q         <= state_n;
      src_rst_q       <= src_rst_n;
      osc_en          <= en_n.osc;
      periph_clk_en   <= en_n.periph;
      cpu_clk_en      <= en_n.cpu;
      imask_clr       <= go_halt;
      wdg_rst_req     <= go_wdg;
      resume_pulse    <= (state_n == ST_RESUME);
      resume_is_reset <= (state_n == ST_RESUME) && src_rst_n;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/halt_seq_ctrl.sv
module halt_seq_ctrl #(
  parameter int SHORT_DELAY = 256,
  parameter int LONG_DELAY  = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       halt_req,
  input  logic       awake_en,
  input  logic       wdg_en,
  input  logic       wdg_halt_opt,
  input  logic       wake_irq,
  input  logic       rst_req,
  input  logic       dly_long,
  input  logic       stab_tick,
  output logic       osc_en,
  output logic       periph_clk_en,
  output logic       cpu_clk_en,
  output logic       imask_clr,
  output logic       wdg_rst_req,
  output logic       resume_pulse,
  output logic       resume_is_reset,
  output logic [1:0] state_o
);
  logic in_run, go_halt, go_wdg;
  logic stab_clr, stab_run, stab_done;

  halt_req_decode u_decode (
    .halt_req     (halt_req),
    .awake_en     (awake_en),
    .wdg_en       (wdg_en),
    .wdg_halt_opt (wdg_halt_opt),
    .in_run       (in_run),
    .go_halt      (go_halt),
    .go_wdg       (go_wdg)
  );

  halt_stab_counter #(
    .SHORT_DELAY (SHORT_DELAY),
    .LONG_DELAY  (LONG_DELAY)
  ) u_counter (
    .clk      (clk),
    .rst      (rst),
    .clr      (stab_clr),
    .long_sel (dly_long),
    .run      (stab_run),
    .tick     (stab_tick),
    .done     (stab_done)
  );

  halt_seq_fsm u_fsm (
    .clk             (clk),
    .rst             (rst),
    .go_halt         (go_halt),
    .go_wdg          (go_wdg),
    .wake_irq        (wake_irq),
    .rst_req         (rst_req),
    .stab_done       (stab_done),
    .in_run          (in_run),
    .stab_clr        (stab_clr),
    .stab_run        (stab_run),
    .osc_en          (osc_en),
    .periph_clk_en   (periph_clk_en),
    .cpu_clk_en      (cpu_clk_en),
    .imask_clr       (imask_clr),
    .wdg_rst_req     (wdg_rst_req),
    .resume_pulse    (resume_pulse),
    .resume_is_reset (resume_is_reset),
    .state_o         (state_o)
  );
endmodule

// File: rtl/halt_seq_checker.sv
module halt_seq_checker (
  input logic       clk,
  input logic       rst,
  input logic       halt_req,
  input logic       awake_en,
  input logic       wdg_en,
  input logic       wdg_halt_opt,
  input logic       wake_irq,
  input logic       rst_req,
  input logic       osc_en,
  input logic       periph_clk_en,
  input logic       cpu_clk_en,
  input logic       imask_clr,
  input logic       wdg_rst_req,
  input logic       resume_pulse,
  input logic [1:0] state_o
);
  AST_IGNORED_WHEN_AWAKE: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0 && halt_req && awake_en) |=> (state_o == 2'd0 && !imask_clr && !wdg_rst_req)); // R1

  AST_MASK_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    imask_clr |=> !imask_clr); // R2

  AST_HALTED_CLOCKS_OFF: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1) |-> (!osc_en && !periph_clk_en && !cpu_clk_en)); // R4

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && !wake_irq && !rst_req) |=> (state_o == 2'd1)); // R5

  AST_STARTUP_GATED: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2) |-> (osc_en && !cpu_clk_en && !periph_clk_en)); // R6

  AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |=> (!resume_pulse && state_o == 2'd0)); // R7

  AST_WDG_INSTEAD: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0 && halt_req && !awake_en && wdg_en && !wdg_halt_opt)
      |=> (wdg_rst_req && state_o == 2'd0)); // R8

  AST_HALT_ALLOWED: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0 && halt_req && !awake_en && (!wdg_en || wdg_halt_opt))
      |=> (imask_clr && state_o != 2'd0)); // R9
endmodule

bind halt_seq_ctrl halt_seq_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .halt_req      (halt_req),
  .awake_en      (awake_en),
  .wdg_en        (wdg_en),
  .wdg_halt_opt  (wdg_halt_opt),
  .wake_irq      (wake_irq),
  .rst_req       (rst_req),
  .osc_en        (osc_en),
  .periph_clk_en (periph_clk_en),
  .cpu_clk_en    (cpu_clk_en),
  .imask_clr     (imask_clr),
  .wdg_rst_req   (wdg_rst_req),
  .resume_pulse  (resume_pulse),
  .state_o       (state_o)
);

// File: tb/halt_seq_ctrl_bench.sv
`timescale 1ns/1ps
module halt_seq_ctrl_bench;
  logic clk = 1'b0;
  logic rst, halt_req, awake_en, wdg_en, wdg_halt_opt, wake_irq, rst_req, dly_long, stab_tick;
  logic osc_en, periph_clk_en, cpu_clk_en, imask_clr, wdg_rst_req, resume_pulse, resume_is_reset;
  logic [1:0] state_o;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles++;

  halt_seq_ctrl u_halt_seq_ctrl (
    .clk(clk), .rst(rst), .halt_req(halt_req), .awake_en(awake_en), .wdg_en(wdg_en),
    .wdg_halt_opt(wdg_halt_opt), .wake_irq(wake_irq), .rst_req(rst_req), .dly_long(dly_long),
    .stab_tick(stab_tick), .osc_en(osc_en), .periph_clk_en(periph_clk_en), .cpu_clk_en(cpu_clk_en),
    .imask_clr(imask_clr), .wdg_rst_req(wdg_rst_req), .resume_pulse(resume_pulse),
    .resume_is_reset(resume_is_reset), .state_o(state_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    halt_req = 0; wake_irq = 0; rst_req = 0; stab_tick = 0;
  endtask

  // Runs STARTUP to completion and checks delay length and resume outcome.
  task automatic finish_startup(input int exp_n, input bit exp_rst, input bit sparse);
    int cnt = 0;
    bit ph = 1'b0;
    check("R6 startup state", state_o, 2);
    check("R6 startup enables osc/cpu/periph", {osc_en, cpu_clk_en, periph_clk_en}, 3'b100);
    while (state_o == 2'd2 && cnt <= exp_n) begin
      stab_tick = sparse ? ph : 1'b1;
      if (stab_tick) cnt++;
      ph = ~ph;
      @(negedge clk);
    end
    stab_tick = 0;
    check("R6 tick count", cnt, exp_n);
    check("R7 resume state", state_o, 3);
    check("R7 resume pulse and clocks", {resume_pulse, osc_en, cpu_clk_en, periph_clk_en}, 4'b1111);
    check("R7/R10 resume_is_reset", resume_is_reset, exp_rst);
    @(negedge clk);
    check("R7 back to run", state_o, 0);
    check("R7 pulse dropped", resume_pulse, 0);
  endtask

  initial begin
    #(150000 * 4);
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1; awake_en = 0; wdg_en = 0; wdg_halt_opt = 0; dly_long = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst = 0;
    check("R11 reset state", state_o, 0);
    check("R11 reset enables", {osc_en, periph_clk_en, cpu_clk_en}, 3'b111);
    check("R11 reset pulses", {imask_clr, wdg_rst_req, resume_pulse}, 3'b000);

    // Configuration sweep: awake_en x wdg_en x wdg_halt_opt, wake source rotates.
    for (int cfg = 0; cfg < 8; cfg++) begin
      automatic bit a = cfg[2], w = cfg[1], o = cfg[0];
      automatic bit wdg_blk = w && !o;
      awake_en = a; wdg_en = w; wdg_halt_opt = o;
      halt_req = 1;
      @(negedge clk);
      halt_req = 0;
      if (a) begin
        check("R1 ignored state", state_o, 0);
        check("R1 ignored outputs", {imask_clr, wdg_rst_req, osc_en, periph_clk_en, cpu_clk_en}, 5'b00111);
      end else if (wdg_blk) begin
        check("R8 wdg reset pulse", wdg_rst_req, 1);
        check("R8 stays run", state_o, 0);
        @(negedge clk);
        check("R8 pulse single", wdg_rst_req, 0);
      end else begin
        check("R9 halted", state_o, 1);
        check("R2 mask clear", imask_clr, 1);
        check("R4 clocks off", {osc_en, periph_clk_en, cpu_clk_en}, 3'b000);
        // Noise on non-wake inputs while halted.
        halt_req = 1; dly_long = 1; stab_tick = 1;
        @(negedge clk);
        check("R2 mask clear single", imask_clr, 0);
        halt_req = 0; dly_long = 0; stab_tick = 0;
        repeat (3) @(negedge clk);
        check("R5 remains halted", state_o, 1);
        dly_long = cfg[0];
        wake_irq = (cfg % 3) != 1;
        rst_req  = (cfg % 3) != 0;
        @(negedge clk);
        begin
          automatic bit exp_r = (cfg % 3) != 0;
          wake_irq = 0; rst_req = 0;
          dly_long = ~dly_long;  // must not affect latched choice
          finish_startup(cfg[0] ? 4096 : 256, exp_r, cfg[1]);
          dly_long = 0;
        end
      end
    end

    // Wake source x delay x tick pattern.
    awake_en = 0; wdg_en = 0; wdg_halt_opt = 0;
    for (int src = 0; src < 3; src++) begin
      for (int d = 0; d < 2; d++) begin
        halt_req = 1;
        @(negedge clk);
        halt_req = 0;
        check("R9 entered halt", state_o, 1);
        dly_long = d[0];
        wake_irq = (src != 1);
        rst_req  = (src != 0);
        @(negedge clk);
        wake_irq = 0; rst_req = 0; dly_long = 0;
        finish_startup(d ? 4096 : 256, src != 0, d == 0);  // R10 when src==2
      end
    end

    // Pending wake at entry: straight to STARTUP.
    for (int src = 0; src < 3; src++) begin
      wdg_en = 1; wdg_halt_opt = 1;
      halt_req = 1;
      wake_irq = (src != 1);
      rst_req  = (src != 0);
      dly_long = 0;
      @(negedge clk);
      halt_req = 0; wake_irq = 0; rst_req = 0;
      check("R3 skip halted", state_o, 2);
      check("R2 mask clear on direct entry", imask_clr, 1);
      finish_startup(256, src != 0, src == 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule